// File: doc/BRIEF.md
# Real-Time Clock Prescaler, Periodic Rate and Interrupt Flags

This block is the timing core of a battery-backed clock. It counts a 32.768 kHz oscillator enable through a 15-stage binary prescaler. It produces the once-per-second update strobe for the calendar logic and an update-in-progress status bit that warns software of an update before it happens. A 4-bit rate code selects one prescaler bit. That bit drives the square-wave pin and sets the periodic event flag.

The block keeps a flag byte holding the periodic, alarm and update-ended flags together with their combined interrupt bit. It drives an active-low interrupt line through an open-drain style drive-enable output. The alarm comparison sits in a neighbouring block, which supplies a one-cycle alarm hit pulse. Two plain write strobes load the control fields: prescaler mode with rate code, and the inhibit bit with the enables. A read strobe held high for the length of a bus read returns the flag byte and clears it when the read ends.

All interfaces are plain control and status pins. There is no data stream and no back-pressure.

Top module: `rtc_rate_irq`

## Requirements
- R1: The prescaler mode is `ctrl_a_wd[6:4]`. Mode 010 advances the 15-bit count on every `osc_tick`. Modes 110 and 111 hold the count at zero. Every other mode freezes the count at its current value.
- R2: After the mode changes from a held-at-zero mode to 010, the first update pulse (`upd_pulse_o`) falls on the 16384th tick. Later pulses follow every 32768 ticks.
- R3: `uip_o` is high during the 8 ticks just before an update and low after it. While the inhibit bit (`ctrl_b_wd[4]`) is 1, `uip_o` stays low and updates do not happen: no pulse and no update flag.
- R4: The rate code is `ctrl_a_wd[3:0]`. Codes 3 to 15 select a tap whose period is 2^(code-1) ticks: 4 ticks for code 3, 256 ticks for code 9, 16384 ticks for code 15.
- R5: Code 1 gives the same 128-tick period as code 8. Code 2 gives the same 256-tick period as code 9.
- R6: Rate code 0 sets no periodic flag and keeps `sqw_o` low.
- R7: `sqw_o` follows the selected tap while the square-wave enable (`ctrl_b_wd[0]`) is 1. It is held low while that enable is 0.
- R8: Flags are set whatever the state of their enables. The periodic flag is set on each rising edge of the selected tap, the alarm flag on `alarm_hit`, and the update flag on each update.
- R9: The interrupt bit is (periodic and its enable `ctrl_b_wd[3]`) or (alarm and `ctrl_b_wd[2]`) or (update and `ctrl_b_wd[1]`). `irq_drive_o` equals that bit. Setting an enable whose flag is already 1 raises `irq_drive_o` in the next cycle.
- R10: The flag byte `flag_rdata` is laid out as follows: bit 7 interrupt, bit 6 periodic, bit 5 alarm, bit 4 update. Bits 3 to 0 always read 0.
- R11: While `flag_rd` is high the flag byte is frozen. When `flag_rd` falls, every flag is cleared. Any event that arrived during the read is then posted, so it is not lost.
- R12: Reset clears the three interrupt enables, the square-wave enable, the inhibit bit and all flags. It also leaves the prescaler held in mode 000 with rate code 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| osc_tick | input | 1 | One-cycle enable at 32.768 kHz |
| ctrl_a_we | input | 1 | Load prescaler mode and rate code |
| ctrl_a_wd | input | 7 | [6:4] prescaler mode, [3:0] rate code |
| ctrl_b_we | input | 1 | Load inhibit bit and enables |
| ctrl_b_wd | input | 5 | [4] inhibit, [3] periodic en, [2] alarm en, [1] update en, [0] square-wave en |
| alarm_hit | input | 1 | One-cycle alarm match pulse from the comparator |
| flag_rd | input | 1 | High for the duration of a flag byte read |
| flag_rdata | output | 8 | Flag byte |
| uip_o | output | 1 | Update-in-progress status |
| upd_pulse_o | output | 1 | One-cycle strobe on the tick that performs the update |
| sqw_o | output | 1 | Square-wave output |
| irq_drive_o | output | 1 | 1 = pull the interrupt line low |

## Verification
The hardest states to reach are the ones tied to the once-per-second update. Reaching them takes tens of thousands of ticks. The update-in-progress window is only 8 ticks wide. An event that lands inside a read is also hard to produce, because it needs a multi-cycle read with a pulse placed in its middle.

The bench drives `osc_tick` on every cycle. It parks the prescaler in the held-at-zero mode and then releases it, so the number of cycles to the first update is known exactly. A free-running cycle counter times the gap to the second update. For the read case, the bench holds `flag_rd` high over several cycles and fires `alarm_hit` inside that window.

// File: rtl/rtc_tick_pkg.sv
package rtc_tick_pkg;

  typedef struct packed {
    logic pf;
    logic af;
    logic uf;
  } rtc_evt_t;

  // prescaler bit selected by a rate code; 0 means no tap
  function automatic logic [3:0] tap_of_code(input logic [3:0] code);
    logic [3:0] r;
    case (code)
      4'd0:    r = 4'd0;
      4'd1:    r = 4'd6;
      4'd2:    r = 4'd7;
      default: r = code - 4'd2;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/rtc_divchain.sv
module rtc_divchain #(
  parameter int STAGES   = 15,
  parameter int UIP_LEAD = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [2:0]        mode,
  input  logic              inhibit,
  output logic [STAGES-1:0] cnt,
  output logic              run_o,
  output logic              uip_o,
  output logic              upd_o
);
  localparam logic [STAGES-1:0] LAST_BEFORE = {1'b0, {(STAGES-1){1'b1}}};
  localparam logic [STAGES-1:0] UIP_FROM    = LAST_BEFORE - STAGES'(UIP_LEAD - 1);

  logic hold;

  assign run_o = (mode == 3'b010);
  assign hold  = (mode[2:1] == 2'b11);

  always_ff @(posedge clk) begin
    if (!rst_n)               cnt <= '0;
    else if (hold)            cnt <= '0;
    else if (run_o && tick)   cnt <= cnt + 1'b1;
  end

  assign upd_o = run_o && tick && !inhibit && (cnt == LAST_BEFORE);
  assign uip_o = run_o && !inhibit && (cnt >= UIP_FROM) && (cnt <= LAST_BEFORE);

  assert_hold_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> (cnt == '0));
  assert_stop_frozen_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_o && !hold) |=> $stable(cnt));
  assert_uip_drops_R3: assert property (@(posedge clk) disable iff (!rst_n)
    upd_o |=> !uip_o);

endmodule

// File: rtl/rtc_rate_tap.sv
module rtc_rate_tap
  import rtc_tick_pkg::*;
#(
  parameter int STAGES = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [STAGES-1:0] cnt,
  input  logic              tick,
  input  logic              run,
  input  logic [3:0]        rate,
  input  logic              sqw_en,
  output logic              pf_evt,
  output logic              sqw_o
);
  logic [STAGES-1:0] nxt;
  logic [STAGES-1:0] rise;
  logic [3:0]        idx;
  logic              valid;

  assign nxt = cnt + 1'b1;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_rise
      assign rise[g] = !cnt[g] && nxt[g];
    end
  endgenerate

  assign idx    = tap_of_code(rate);
  assign valid  = (rate != 4'd0);
  assign pf_evt = tick && run && valid && rise[idx];
  assign sqw_o  = sqw_en && valid && cnt[idx];

  assert_code0_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rate == 4'd0) |-> (!pf_evt && !sqw_o));
  assert_sqw_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !sqw_en |-> !sqw_o);

endmodule

// File: rtl/rtc_flag_unit.sv
module rtc_flag_unit
  import rtc_tick_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  rtc_evt_t   evt,
  input  rtc_evt_t   en,
  input  logic       rd_i,
  output logic [7:0] rdata,
  output logic       irq_o
);
  rtc_evt_t flg_q, pend_q;
  logic     rd_d;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flg_q  <= '0;
      pend_q <= '0;
      rd_d   <= 1'b0;
    end else begin
      rd_d <= rd_i;
      if (rd_i) begin
        pend_q <= pend_q | evt;
      end else if (rd_d) begin
        flg_q  <= pend_q | evt;
        pend_q <= '0;
      end else begin
        flg_q  <= flg_q | evt;
      end
    end
  end

  assign irq_o = |(flg_q & en);
  assign rdata = {irq_o, flg_q.pf, flg_q.af, flg_q.uf, 4'b0000};

  assert_read_frozen_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rd_i |=> $stable(flg_q));
  assert_pf_sticks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_i && !rd_d && evt.pf) |=> flg_q.pf);
  assert_irq_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (flg_q.af && en.af) |-> irq_o);

endmodule

// File: rtl/rtc_rate_irq.sv
module rtc_rate_irq
  import rtc_tick_pkg::*;
#(
  parameter int STAGES   = 15,
  parameter int UIP_LEAD = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       osc_tick,
  input  logic       ctrl_a_we,
  input  logic [6:0] ctrl_a_wd,
  input  logic       ctrl_b_we,
  input  logic [4:0] ctrl_b_wd,
  input  logic       alarm_hit,
  input  logic       flag_rd,
  output logic [7:0] flag_rdata,
  output logic       uip_o,
  output logic       upd_pulse_o,
  output logic       sqw_o,
  output logic       irq_drive_o
);
  logic [2:0]        mode_q;
  logic [3:0]        rate_q;
  logic              inhibit_q, sqwe_q;
  rtc_evt_t          en_q, evt;
  logic [STAGES-1:0] cnt;
  logic              run, pf_evt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q    <= 3'b000;
      rate_q    <= 4'd0;
      inhibit_q <= 1'b0;
      en_q      <= '0;
      sqwe_q    <= 1'b0;
    end else begin
      if (ctrl_a_we) begin
        mode_q <= ctrl_a_wd[6:4];
        rate_q <= ctrl_a_wd[3:0];
      end
      if (ctrl_b_we) begin
        inhibit_q <= ctrl_b_wd[4];
        en_q      <= '{pf: ctrl_b_wd[3], af: ctrl_b_wd[2], uf: ctrl_b_wd[1]};
        sqwe_q    <= ctrl_b_wd[0];
      end
    end
  end

  rtc_divchain #(.STAGES(STAGES), .UIP_LEAD(UIP_LEAD)) u_chain (
    .clk(clk), .rst_n(rst_n), .tick(osc_tick), .mode(mode_q),
    .inhibit(inhibit_q), .cnt(cnt), .run_o(run), .uip_o(uip_o),
    .upd_o(upd_pulse_o)
  );

  rtc_rate_tap #(.STAGES(STAGES)) u_tap (
    .clk(clk), .rst_n(rst_n), .cnt(cnt), .tick(osc_tick), .run(run),
    .rate(rate_q), .sqw_en(sqwe_q), .pf_evt(pf_evt), .sqw_o(sqw_o)
  );

  assign evt = '{pf: pf_evt, af: alarm_hit, uf: upd_pulse_o};

  rtc_flag_unit u_flags (
    .clk(clk), .rst_n(rst_n), .evt(evt), .en(en_q), .rd_i(flag_rd),
    .rdata(flag_rdata), .irq_o(irq_drive_o)
  );

  assert_inhibit_no_update_R3: assert property (@(posedge clk) disable iff (!rst_n)
    inhibit_q |-> (!upd_pulse_o && !uip_o));
  assert_low_nibble_R10: assert property (@(posedge clk) disable iff (!rst_n)
    flag_rdata[3:0] == 4'b0000);

endmodule

// File: tb/test_rtc_rate_irq.sv
module test_rtc_rate_irq;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 190000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       osc_tick = 1'b1;
  logic       ctrl_a_we = 1'b0;
  logic [6:0] ctrl_a_wd = '0;
  logic       ctrl_b_we = 1'b0;
  logic [4:0] ctrl_b_wd = '0;
  logic       alarm_hit = 1'b0;
  logic       flag_rd = 1'b0;
  logic [7:0] flag_rdata;
  logic       uip_o, upd_pulse_o, sqw_o, irq_drive_o;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  rtc_rate_irq i_rtc_rate_irq (
    .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick),
    .ctrl_a_we(ctrl_a_we), .ctrl_a_wd(ctrl_a_wd),
    .ctrl_b_we(ctrl_b_we), .ctrl_b_wd(ctrl_b_wd),
    .alarm_hit(alarm_hit), .flag_rd(flag_rd), .flag_rdata(flag_rdata),
    .uip_o(uip_o), .upd_pulse_o(upd_pulse_o), .sqw_o(sqw_o),
    .irq_drive_o(irq_drive_o)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic wr_a(input logic [2:0] mode, input logic [3:0] rate);
    @(negedge clk); ctrl_a_we = 1'b1; ctrl_a_wd = {mode, rate};
    @(negedge clk); ctrl_a_we = 1'b0;
  endtask

  task automatic wr_b(input logic inh, input logic pe, input logic ae, input logic ue, input logic se);
    @(negedge clk); ctrl_b_we = 1'b1; ctrl_b_wd = {inh, pe, ae, ue, se};
    @(negedge clk); ctrl_b_we = 1'b0;
  endtask

  task automatic read_flags(output logic [7:0] d);
    @(negedge clk); flag_rd = 1'b1;
    @(negedge clk); d = flag_rdata; flag_rd = 1'b0;
    @(negedge clk);
  endtask

  task automatic wait_rise();
    logic p;
    p = sqw_o;
    forever begin
      @(negedge clk);
      if (!p && sqw_o) break;
      p = sqw_o;
    end
  endtask

  task automatic measure(input logic [3:0] code, output int period);
    logic [7:0] d;
    logic p;
    wr_a(3'b010, code);
    read_flags(d);
    wait_rise();
    chk("R8", "periodic flag at tap rise with enable off", int'(flag_rdata[6]), 1);
    period = 0;
    p = sqw_o;
    forever begin
      @(negedge clk);
      period++;
      if (!p && sqw_o) break;
      p = sqw_o;
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R12", "flags after reset", int'(flag_rdata), 0);
    chk("R12", "irq after reset", int'(irq_drive_o), 0);
    chk("R12", "sqw after reset", int'(sqw_o), 0);
    chk("R12", "uip after reset", int'(uip_o), 0);
  endtask

  task automatic t_modes();
    int ones, changes;
    logic p;
    wr_b(0, 0, 0, 0, 1);
    wr_a(3'b110, 4'd3);
    ones = 0;
    repeat (20) begin @(negedge clk); if (sqw_o) ones++; end
    chk("R1", "held-at-zero mode keeps tap low", ones, 0);
    wr_a(3'b010, 4'd3);
    changes = 0; p = sqw_o;
    repeat (16) begin @(negedge clk); if (sqw_o != p) changes++; p = sqw_o; end
    chk("R1", "running mode tap changes in 16 ticks", changes, 8);
    wr_a(3'b000, 4'd3);
    changes = 0; p = sqw_o;
    repeat (20) begin @(negedge clk); if (sqw_o != p) changes++; p = sqw_o; end
    chk("R1", "stopped mode freezes count", changes, 0);
  endtask

  task automatic t_rates();
    int pa, pb;
    wr_b(0, 0, 0, 0, 1);
    measure(4'd3, pa);  chk("R4", "code 3 period", pa, 4);
    measure(4'd9, pa);  chk("R4", "code 9 period", pa, 256);
    measure(4'd1, pa);  measure(4'd8, pb);
    chk("R5", "code 1 period", pa, 128);
    chk("R5", "code 1 equals code 8", pa, pb);
    measure(4'd2, pa);  chk("R5", "code 2 period", pa, 256);
    measure(4'd15, pa); chk("R4", "code 15 period", pa, 16384);
  endtask

  task automatic t_code0();
    logic [7:0] d;
    int ones;
    wr_b(0, 0, 0, 0, 1);
    wr_a(3'b010, 4'd0);
    read_flags(d);
    ones = 0;
    repeat (600) begin @(negedge clk); if (sqw_o) ones++; end
    chk("R6", "code 0 sqw high samples", ones, 0);
    chk("R6", "code 0 periodic flag", int'(flag_rdata[6]), 0);
  endtask

  task automatic t_sqw_off_and_irq();
    logic [7:0] d;
    int ones;
    wr_b(0, 0, 0, 0, 0);
    wr_a(3'b010, 4'd3);
    read_flags(d);
    ones = 0;
    repeat (20) begin @(negedge clk); if (sqw_o) ones++; end
    chk("R7", "sqw held low with enable 0", ones, 0);
    chk("R8", "periodic flag set with sqw and irq enables off", int'(flag_rdata[6]), 1);
    chk("R9", "no irq while periodic enable 0", int'(irq_drive_o), 0);
    wr_b(0, 1, 0, 0, 0);
    chk("R9", "irq right after enabling pending periodic", int'(irq_drive_o), 1);
    chk("R10", "flag byte bit 7 interrupt", int'(flag_rdata[7]), 1);
  endtask

  task automatic t_read_hold();
    logic [7:0] d;
    wr_b(0, 0, 0, 0, 0);
    wr_a(3'b110, 4'd0);
    read_flags(d);
    chk("R11", "flags cleared after read", int'(flag_rdata), 0);
    @(negedge clk); alarm_hit = 1'b1;
    @(negedge clk); alarm_hit = 1'b0;
    chk("R8", "alarm flag with alarm enable 0", int'(flag_rdata), 8'h20);
    chk("R9", "no irq with alarm enable 0", int'(irq_drive_o), 0);
    wr_b(0, 0, 1, 0, 0);
    chk("R9", "irq after enabling pending alarm", int'(irq_drive_o), 1);
    @(negedge clk); flag_rd = 1'b1;
    @(negedge clk);
    chk("R10", "flag byte during read", int'(flag_rdata), 8'hA0);
    alarm_hit = 1'b1;
    @(negedge clk); alarm_hit = 1'b0;
    @(negedge clk);
    chk("R11", "flag byte frozen during read", int'(flag_rdata), 8'hA0);
    flag_rd = 1'b0;
    @(negedge clk);
    chk("R11", "alarm during read posted after read", int'(flag_rdata), 8'hA0);
    read_flags(d);
    chk("R11", "all flags cleared after read", int'(flag_rdata), 0);
    chk("R11", "irq released after read", int'(irq_drive_o), 0);
  endtask

  task automatic t_update();
    logic [7:0] d;
    int n, nuip, nupd, c1, c2;
    wr_b(0, 0, 0, 0, 0);
    wr_a(3'b110, 4'd0);
    read_flags(d);
    wr_a(3'b010, 4'd0);
    n = 0; nuip = 0; nupd = 0; c1 = 0;
    while (!flag_rdata[4] && n < 20000) begin
      @(negedge clk);
      n++;
      if (uip_o) nuip++;
      if (upd_pulse_o) begin nupd++; c1 = cyc; end
    end
    chk("R2", "ticks from release to first update", n, 16384);
    chk("R2", "update pulses before first flag", nupd, 1);
    chk("R3", "uip high samples before update", nuip, 8);
    chk("R3", "uip low after update", int'(uip_o), 0);
    chk("R8", "update flag with update enable 0", int'(flag_rdata), 8'h10);
    wr_b(0, 0, 0, 1, 0);
    chk("R9", "irq after enabling pending update", int'(irq_drive_o), 1);
    n = 0;
    do begin @(negedge clk); n++; end while (!upd_pulse_o && n < 40000);
    c2 = cyc;
    chk("R2", "ticks between updates", c2 - c1, 32768);
  endtask

  task automatic t_inhibit();
    logic [7:0] d;
    int nuip, nupd;
    wr_b(1, 0, 0, 1, 0);
    read_flags(d);
    nuip = 0; nupd = 0;
    repeat (32800) begin
      @(negedge clk);
      if (uip_o) nuip++;
      if (upd_pulse_o) nupd++;
    end
    chk("R3", "uip samples while inhibited", nuip, 0);
    chk("R3", "update pulses while inhibited", nupd, 0);
    chk("R3", "update flag while inhibited", int'(flag_rdata[4]), 0);
  endtask

  task automatic t_reset_mid();
    int ones;
    wr_b(0, 1, 1, 1, 1);
    wr_a(3'b010, 4'd3);
    repeat (10) @(negedge clk);
    chk("R9", "irq from periodic before reset", int'(irq_drive_o), 1);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R12", "flags after mid reset", int'(flag_rdata), 0);
    chk("R12", "irq after mid reset", int'(irq_drive_o), 0);
    wr_a(3'b010, 4'd3);
    ones = 0;
    repeat (12) begin @(negedge clk); if (sqw_o) ones++; end
    chk("R12", "sqw enable cleared by reset", ones, 0);
    chk("R12", "periodic enable cleared by reset", int'(irq_drive_o), 0);
    chk("R12", "periodic flag still sets after reset", int'(flag_rdata[6]), 1);
  endtask

  initial begin
    t_reset();
    t_modes();
    t_rates();
    t_code0();
    t_sqw_off_and_irq();
    t_read_hold();
    t_update();
    t_inhibit();
    t_reset_mid();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", WATCHDOG, 0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule